// File: doc/BRIEF.md
# Pointer Data Address Generator

This block forms the effective data-memory address for an 8-bit microcontroller core. It holds the 32 general-purpose 8-bit working registers. The six highest-numbered registers also act as three 16-bit pointers, named X, Y and Z. Each request gives an addressing mode, a pointer select and a 16-bit field from the instruction. The block returns the effective address and a one-hot region decode that says whether the address falls in the working registers, the I/O window or data SRAM. For auto-update modes it also returns a pointer write-back value and enable, and it writes that value into the pointer registers itself.

A separate general write port loads and modifies any working register, pointer bytes included. A combinational read port shows the contents of any register. A request that is not allowed is flagged as illegal, and it makes no memory access and changes no register.

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is held, every output is 0 and every working register reads back as 0.
- R2: A general write (regWe) stores regWdata into register regWaddr. X is built from R27 (high byte) and R26 (low byte), Y from R29 and R28, and Z from R31 and R30. ptrSel selects the pointer: 0 picks X, 1 picks Y, 2 picks Z, and 3 is reserved.
- R3: Mode 0 (direct) uses all 16 bits of instField as the effective address.
- R4: Mode 1 (I/O direct) takes instField[5:0] as the I/O register number n and produces the address n + 0x20.
- R5: Mode 2 (indirect) uses the selected pointer unchanged as the address and never raises wbEn.
- R6: Mode 3 (displacement) adds instField[5:0], an unsigned value from 0 to 63, to Y or Z, wrapping modulo 2^16. It never raises wbEn.
- R7: Any of the following raises illegal with addrValid, wbEn and all region outputs at 0, and changes no register: mode 3 with X as the base, a pointer mode (2 to 5) with ptrSel 3, or a mode code of 6 or 7.
- R8: Mode 4 (pre-decrement) uses pointer−1 as the address, writes pointer−1 back and raises wbEn. 0x0000 wraps to 0xFFFF.
- R9: Mode 5 (post-increment) uses the pointer as the address, writes pointer+1 back and raises wbEn. 0xFFFF wraps to 0x0000.
- R10: When addrValid is 1, exactly one region output is 1: hitReg for addresses below 0x20, hitIo for 0x20 to 0x5F, and hitSram above that. When addrValid is 0, all three are 0.
- R11: All outputs are registered and answer a request on the next clock edge. A cycle with reqValid low gives addrValid, illegal and wbEn all 0. effAddr is 0 whenever addrValid is 0, and wbValue is 0 whenever wbEn is 0.
- R12: If a general write targets a byte of the pointer being written back in the same cycle, the write-back value wins for that byte. A general write to any other register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Address request strobe |
| mode | input | 3 | Addressing mode code |
| ptrSel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| instField | input | 16 | Direct address, I/O number or displacement |
| regWe | input | 1 | General register write enable |
| regWaddr | input | 5 | General write register index |
| regWdata | input | 8 | General write data |
| regRaddr | input | 5 | Read-back register index |
| regRdata | output | 8 | Read-back register contents |
| addrValid | output | 1 | Registered: an access is made |
| effAddr | output | 16 | Registered effective address |
| hitReg | output | 1 | Address is in the working registers |
| hitIo | output | 1 | Address is in the I/O window |
| hitSram | output | 1 | Address is in data SRAM |
| illegal | output | 1 | Request was refused |
| wbEn | output | 1 | Pointer write-back happened |
| wbValue | output | 16 | Value written back to the pointer |

## Verification
A pointer write-back and a general register write can happen in the same cycle, and either may target the same pointer bytes. The bench creates this clash on purpose. It issues a post-increment on Y in the same cycle as a general write to R28, then reads R28 back. The random phase sends about half of all general writes to pointer registers while auto-update modes run. A behavioural model applies the general write first and the write-back last. It predicts every register and every output, and the bench compares the design against it at each falling edge.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  // Mode codes seen at the mode port; 6 and 7 are refused.
  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IODIR   = 3'd1,
    AM_IND     = 3'd2,
    AM_DISP    = 3'd3,
    AM_PREDEC  = 3'd4,
    AM_POSTINC = 3'd5
  } addr_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic access;     // a memory access is made
    logic useField;   // address comes from the instruction field
    logic ioOffset;   // add the I/O window base to the 6-bit field
    logic addDisp;    // add the 6-bit displacement to the pointer
    logic dec;        // pointer minus one (address and write-back)
    logic writeBack;  // update the selected pointer
    logic illegal;    // request refused
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import ptr_agu_pkg::*;
#(
  parameter int NUM_PTRS = 3,
  parameter int SEL_W    = 2,
  parameter int DISP_LO  = 1   // lowest pointer index allowed as displacement base
) (
  input  logic             reqValid,
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] ptrSel,
  output agu_strobe_t      strb
);

  logic ptrOk;
  logic dispOk;

  assign ptrOk  = int'(ptrSel) < NUM_PTRS;
  assign dispOk = ptrOk && (int'(ptrSel) >= DISP_LO);

  always_comb begin
    strb = '0;
    if (reqValid) begin
      case (mode)
        AM_DIRECT: begin
          strb.access   = 1'b1;
          strb.useField = 1'b1;
        end
        AM_IODIR: begin
          strb.access   = 1'b1;
          strb.useField = 1'b1;
          strb.ioOffset = 1'b1;
        end
        AM_IND: begin
          strb.access  = ptrOk;
          strb.illegal = !ptrOk;
        end
        AM_DISP: begin
          strb.access  = dispOk;
          strb.addDisp = dispOk;
          strb.illegal = !dispOk;
        end
        AM_PREDEC: begin
          strb.access    = ptrOk;
          strb.dec       = ptrOk;
          strb.writeBack = ptrOk;
          strb.illegal   = !ptrOk;
        end
        AM_POSTINC: begin
          strb.access    = ptrOk;
          strb.writeBack = ptrOk;
          strb.illegal   = !ptrOk;
        end
        default: strb.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import ptr_agu_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int IO_COUNT = 64,
  parameter int DISP_W   = 6,
  parameter int NUM_PTRS = 3,
  parameter int SEL_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  agu_strobe_t                 strb,
  input  logic [SEL_W-1:0]            ptrSel,
  input  logic [ADDR_W-1:0]           instField,
  input  logic                        regWe,
  input  logic [$clog2(NUM_REGS)-1:0] regWaddr,
  input  logic [DATA_W-1:0]           regWdata,
  input  logic [$clog2(NUM_REGS)-1:0] regRaddr,
  output logic [DATA_W-1:0]           regRdata,
  output logic                        addrValid,
  output logic [ADDR_W-1:0]           effAddr,
  output logic                        hitReg,
  output logic                        hitIo,
  output logic                        hitSram,
  output logic                        illegal,
  output logic                        wbEn,
  output logic [ADDR_W-1:0]           wbValue
);

  localparam int REG_AW    = $clog2(NUM_REGS);
  localparam int IO_AW     = $clog2(IO_COUNT);
  localparam int PTR_BASE  = NUM_REGS - 2 * NUM_PTRS;
  localparam int SEL_SLOTS = 2 ** SEL_W;
  localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(NUM_REGS + IO_COUNT);

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [ADDR_W-1:0] ptrWord [SEL_SLOTS];

  // Pointer views over the top register pairs; unused select slots read 0.
  for (genvar p = 0; p < SEL_SLOTS; p++) begin : g_ptr
    if (p < NUM_PTRS) begin : g_live
      assign ptrWord[p] = ADDR_W'({regFile[PTR_BASE + 2*p + 1], regFile[PTR_BASE + 2*p]});
    end else begin : g_none
      assign ptrWord[p] = '0;
    end
  end

  logic [ADDR_W-1:0] ptrCur;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] wbNext;
  logic [REG_AW-1:0] loIdx;
  logic [REG_AW-1:0] hiIdx;

  assign ptrCur  = ptrWord[ptrSel];
  assign dispExt = strb.addDisp ? ADDR_W'(instField[DISP_W-1:0]) : '0;
  assign wbNext  = strb.dec ? ptrCur - ADDR_W'(1) : ptrCur + ADDR_W'(1);
  assign loIdx   = REG_AW'(PTR_BASE) + REG_AW'({ptrSel, 1'b0});
  assign hiIdx   = loIdx + REG_AW'(1);

  always_comb begin
    if (strb.useField) begin
      addrNext = strb.ioOffset ? IO_BASE + ADDR_W'(instField[IO_AW-1:0]) : instField;
    end else if (strb.dec) begin
      addrNext = wbNext;
    end else begin
      addrNext = ptrCur + dispExt;
    end
  end

  logic inRegs;
  logic inIo;

  assign inRegs = addrNext < IO_BASE;
  assign inIo   = !inRegs && (addrNext < SRAM_BASE);

  // Register file: the pointer write-back is applied after the general write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (regWe) regFile[regWaddr] <= regWdata;
      if (strb.writeBack) begin
        regFile[loIdx] <= wbNext[DATA_W-1:0];
        regFile[hiIdx] <= wbNext[2*DATA_W-1:DATA_W];
      end
    end
  end

  assign regRdata = regFile[regRaddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      effAddr   <= '0;
      hitReg    <= 1'b0;
      hitIo     <= 1'b0;
      hitSram   <= 1'b0;
      illegal   <= 1'b0;
      wbEn      <= 1'b0;
      wbValue   <= '0;
    end else begin
      addrValid <= strb.access;
      effAddr   <= strb.access ? addrNext : '0;
      hitReg    <= strb.access && inRegs;
      hitIo     <= strb.access && inIo;
      hitSram   <= strb.access && !inRegs && !inIo;
      illegal   <= strb.illegal;
      wbEn      <= strb.writeBack;
      wbValue   <= strb.writeBack ? wbNext : '0;
    end
  end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_agu_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int IO_COUNT = 64,
  parameter int DISP_W   = 6,
  parameter int NUM_PTRS = 3,
  parameter int SEL_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [2:0]                  mode,
  input  logic [SEL_W-1:0]            ptrSel,
  input  logic [ADDR_W-1:0]           instField,
  input  logic                        regWe,
  input  logic [$clog2(NUM_REGS)-1:0] regWaddr,
  input  logic [DATA_W-1:0]           regWdata,
  input  logic [$clog2(NUM_REGS)-1:0] regRaddr,
  output logic [DATA_W-1:0]           regRdata,
  output logic                        addrValid,
  output logic [ADDR_W-1:0]           effAddr,
  output logic                        hitReg,
  output logic                        hitIo,
  output logic                        hitSram,
  output logic                        illegal,
  output logic                        wbEn,
  output logic [ADDR_W-1:0]           wbValue
);

  agu_strobe_t strb;

  agu_ctrl #(
    .NUM_PTRS(NUM_PTRS),
    .SEL_W   (SEL_W),
    .DISP_LO (1)
  ) u_ctrl (
    .reqValid(reqValid),
    .mode    (mode),
    .ptrSel  (ptrSel),
    .strb    (strb)
  );

  agu_datapath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .IO_COUNT(IO_COUNT),
    .DISP_W  (DISP_W),
    .NUM_PTRS(NUM_PTRS),
    .SEL_W   (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ptrSel   (ptrSel),
    .instField(instField),
    .regWe    (regWe),
    .regWaddr (regWaddr),
    .regWdata (regWdata),
    .regRaddr (regRaddr),
    .regRdata (regRdata),
    .addrValid(addrValid),
    .effAddr  (effAddr),
    .hitReg   (hitReg),
    .hitIo    (hitIo),
    .hitSram  (hitSram),
    .illegal  (illegal),
    .wbEn     (wbEn),
    .wbValue  (wbValue)
  );

endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        mode,
  input logic              addrValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic              hitReg,
  input logic              hitIo,
  input logic              hitSram,
  input logic              illegal,
  input logic              wbEn,
  input logic [ADDR_W-1:0] wbValue
);

  logic pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $countones({hitReg, hitIo, hitSram}) == 1); // R10

  AST_REGION_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> {hitReg, hitIo, hitSram} == 3'b000); // R10

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hitReg |-> effAddr < ADDR_W'(NUM_REGS)); // R10

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !addrValid && !wbEn); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(!reqValid) |-> !addrValid && !illegal && !wbEn); // R11

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && wbEn && $past(mode) == 3'd5 |-> wbValue == ADDR_W'(effAddr + ADDR_W'(1))); // R9

  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && wbEn && $past(mode) == 3'd4 |-> wbValue == effAddr); // R8

  AST_NO_WB_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(reqValid) && ($past(mode) == 3'd2 || $past(mode) == 3'd3) |-> !wbEn); // R6

endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .mode     (mode),
  .addrValid(addrValid),
  .effAddr  (effAddr),
  .hitReg   (hitReg),
  .hitIo    (hitIo),
  .hitSram  (hitSram),
  .illegal  (illegal),
  .wbEn     (wbEn),
  .wbValue  (wbValue)
);

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic [15:0] instField = '0;
  logic        regWe = 1'b0;
  logic [4:0]  regWaddr = '0;
  logic [7:0]  regWdata = '0;
  logic [4:0]  regRaddr = '0;
  logic [7:0]  regRdata;
  logic        addrValid, hitReg, hitIo, hitSram, illegal, wbEn;
  logic [15:0] effAddr, wbValue;

  always #4 clk = ~clk;  // 125 MHz

  ptr_addr_gen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .ptrSel(ptrSel),
    .instField(instField), .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .regRaddr(regRaddr), .regRdata(regRdata), .addrValid(addrValid), .effAddr(effAddr),
    .hitReg(hitReg), .hitIo(hitIo), .hitSram(hitSram), .illegal(illegal),
    .wbEn(wbEn), .wbValue(wbValue)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference model.
  logic [7:0]  mReg [32];
  logic        eValid = 0, eIll = 0, eWb = 0;
  logic [15:0] eAddr = 0, eWbVal = 0;
  logic [2:0]  eRegion = 0;
  string       eTag = "R1";
  string       rTag = "R1";

  initial for (int i = 0; i < 32; i++) mReg[i] = 8'h00;

  always @(posedge clk) begin : model
    logic [15:0] p, a, w;
    logic        v, ill, wb, selOk;
    int          lo;
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mReg[i] = 8'h00;
      eValid = 0; eIll = 0; eWb = 0; eAddr = 0; eWbVal = 0; eRegion = 0;
      eTag = "R1"; rTag = "R1";
    end else begin
      selOk = (ptrSel != 2'd3);
      lo = 26 + 2 * int'(ptrSel);
      p = selOk ? {mReg[lo + 1], mReg[lo]} : 16'h0000;
      v = 0; ill = 0; wb = 0; a = 0; w = 0;
      if (!reqValid) eTag = "R11";
      else begin
        case (mode)
          3'd0: begin v = 1; a = instField; eTag = "R3"; end
          3'd1: begin v = 1; a = 16'h0020 + {10'd0, instField[5:0]}; eTag = "R4"; end
          3'd2: begin v = selOk; ill = !selOk; a = p; eTag = selOk ? "R5" : "R7"; end
          3'd3: begin
            if (ptrSel == 2'd1 || ptrSel == 2'd2) begin
              v = 1; a = p + {10'd0, instField[5:0]}; eTag = "R6";
            end else begin ill = 1; eTag = "R7"; end
          end
          3'd4: begin
            v = selOk; ill = !selOk; wb = selOk; a = p - 16'd1; w = a; eTag = selOk ? "R8" : "R7";
          end
          3'd5: begin
            v = selOk; ill = !selOk; wb = selOk; a = p; w = p + 16'd1; eTag = selOk ? "R9" : "R7";
          end
          default: begin ill = 1; eTag = "R7"; end
        endcase
      end
      eValid = v; eIll = ill; eWb = wb;
      eAddr  = v ? a : 16'h0000;
      eWbVal = wb ? w : 16'h0000;
      if (!v) eRegion = 3'b000;
      else if (a < 16'h0020) eRegion = 3'b100;
      else if (a < 16'h0060) eRegion = 3'b010;
      else eRegion = 3'b001;
      rTag = "R2";
      if (regWe) mReg[regWaddr] = regWdata;
      if (wb) begin
        if (regWe && (int'(regWaddr) == lo || int'(regWaddr) == lo + 1)) rTag = "R12";
        mReg[lo] = w[7:0];
        mReg[lo + 1] = w[15:8];
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    check(eTag, {29'd0, addrValid, effAddr, illegal, wbEn, wbValue},
                {29'd0, eValid, eAddr, eIll, eWb, eWbVal});
    check(rstN ? "R10" : "R1", {61'd0, hitReg, hitIo, hitSram}, {61'd0, eRegion});
    check(rTag, {56'd0, regRdata}, {56'd0, mReg[regRaddr]});
  endtask

  task automatic step(input logic v, input logic [2:0] md, input logic [1:0] sel,
                      input logic [15:0] f, input logic we, input logic [4:0] wa,
                      input logic [7:0] wd, input logic [4:0] ra);
    @(negedge clk);
    compare();
    reqValid = v; mode = md; ptrSel = sel; instField = f;
    regWe = we; regWaddr = wa; regWdata = wd; regRaddr = ra;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [7:0] d);
    step(0, 3'd0, 2'd0, 16'h0, 1, idx, d, idx);
  endtask

  initial begin
    // R1: reset state
    repeat (3) step(0, 3'd0, 2'd0, 16'h0, 0, 5'd0, 8'h0, 5'd26);
    @(negedge clk);
    rstN = 1'b1;
    // R2: load X=0x0010, Y=0x0040, Z=0xFFFF
    wr(5'd26, 8'h10); wr(5'd27, 8'h00);
    wr(5'd28, 8'h40); wr(5'd29, 8'h00);
    wr(5'd30, 8'hFF); wr(5'd31, 8'hFF);
    step(1, 3'd0, 2'd0, 16'h1234, 0, 5'd0, 8'h0, 5'd27);  // R3 SRAM
    step(1, 3'd0, 2'd0, 16'h0005, 0, 5'd0, 8'h0, 5'd26);  // R3 register region
    step(1, 3'd1, 2'd0, 16'hFF3F, 0, 5'd0, 8'h0, 5'd26);  // R4 top of I/O
    step(1, 3'd1, 2'd0, 16'h0000, 0, 5'd0, 8'h0, 5'd26);  // R4 bottom of I/O
    step(1, 3'd2, 2'd0, 16'h0000, 0, 5'd0, 8'h0, 5'd26);  // R5 X
    step(1, 3'd3, 2'd1, 16'h003F, 0, 5'd0, 8'h0, 5'd28);  // R6 Y+63
    step(1, 3'd3, 2'd2, 16'hFFC1, 0, 5'd0, 8'h0, 5'd30);  // R6 Z+1 wraps
    step(1, 3'd3, 2'd0, 16'h0001, 0, 5'd0, 8'h0, 5'd26);  // R7 X displacement
    step(1, 3'd2, 2'd3, 16'h0000, 0, 5'd0, 8'h0, 5'd26);  // R7 reserved select
    step(1, 3'd6, 2'd1, 16'h0000, 0, 5'd0, 8'h0, 5'd28);  // R7 bad mode
    step(1, 3'd5, 2'd2, 16'h0000, 0, 5'd0, 8'h0, 5'd30);  // R9 Z wraps to 0
    step(1, 3'd5, 2'd2, 16'h0000, 0, 5'd0, 8'h0, 5'd31);  // R9 back-to-back
    step(1, 3'd4, 2'd0, 16'h0000, 0, 5'd0, 8'h0, 5'd26);  // R8 X-1
    wr(5'd28, 8'h00);
    step(1, 3'd4, 2'd1, 16'h0000, 0, 5'd0, 8'h0, 5'd28);  // R8 Y wraps to 0xFFFF
    step(1, 3'd5, 2'd1, 16'h0000, 1, 5'd28, 8'hAA, 5'd28); // R12 clash on R28
    step(1, 3'd5, 2'd1, 16'h0000, 1, 5'd3, 8'h5C, 5'd3);   // R12 other register kept
    step(0, 3'd5, 2'd1, 16'h0000, 0, 5'd0, 8'h0, 5'd29);   // R11 idle
    for (int n = 0; n < 600; n++) begin
      logic [4:0] wa;
      wa = ($urandom % 2 == 0) ? 5'(26 + $urandom % 6) : 5'($urandom % 32);
      step($urandom % 5 != 0, 3'($urandom % 8), 2'($urandom % 4), 16'($urandom),
           $urandom % 3 == 0, wa, 8'($urandom), 5'($urandom % 32));
    end
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule